// File: doc/BRIEF.md
# Extended Sequence Number Window Tracker

This block holds the extended sequence number state of one security association in an ESP datapath. On each update strobe it takes a 32-bit low sequence word and a 32-bit high word from the receive pair or the transmit pair, as a direction input selects. It also takes the anti-replay window size. From these it derives the bottom of the replay window and stores the low word, the high word and the bottom.

An overlap bit records whether the window bottom lies in the lower or the upper half of the 32-bit sequence space. Each time that bit flips, the block raises a one-cycle update pulse. A context store further down the datapath then rewrites its copy of the association. Ordinary sequence advances do not disturb it.

On the receive side the window size is reduced to a 2-bit code. A size the block cannot represent is refused with an error flag, and the stored state is left unchanged.

Top module: `esn_track_top`

## Requirements
- R1: On an accepted strobe the stored window bottom becomes (low − size + 1) when the selected low word is at least the window size. Otherwise it becomes 0. The arithmetic is 32-bit unsigned.
- R2: When the overlap bit is 1 and the new bottom is below 2^31, the overlap bit becomes 0.
- R3: When the overlap bit is 0 and the new bottom is 2^31 or higher, the overlap bit becomes 1.
- R4: When the high word stored before the strobe is zero and the selected low word is zero, the stored low word becomes 1. Otherwise the stored low word is the selected low word.
- R5: With `dir_rx`=1 the receive pair (`rx_seq_lo`, `rx_seq_hi`) is stored. With `dir_rx`=0 the transmit pair (`tx_seq_lo`, `tx_seq_hi`) is stored.
- R6: `ctx_update` is 1 for the single cycle after an accepted strobe that flips the overlap bit, and 0 in every other cycle.
- R7: A receive strobe with size 32, 64, 128 or 256 sets `win_code` to 0, 1, 2 or 3 respectively. A transmit strobe leaves `win_code` unchanged and never raises `win_err`, whatever its size.
- R8: A receive strobe with any other size sets `win_err` and changes no stored value. `win_err` holds until the next strobe, which rewrites it.
- R9: Synchronous active-high reset clears the stored words, the bottom, the overlap bit, the window code, `win_err` and `ctx_update`.
- R10: Without a strobe no output changes, and `ctx_update` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Single-cycle update strobe |
| dir_rx | input | 1 | 1 = receive pair and window code, 0 = transmit pair |
| rx_seq_lo | input | 32 | Receive low sequence word |
| rx_seq_hi | input | 32 | Receive high sequence word |
| tx_seq_lo | input | 32 | Transmit low sequence word |
| tx_seq_hi | input | 32 | Transmit high sequence word |
| win_size | input | 16 | Anti-replay window size in packets |
| seq_lo | output | 32 | Stored low word |
| seq_hi | output | 32 | Stored high word |
| win_bottom | output | 32 | Stored replay window bottom |
| overlap | output | 1 | 1 = window bottom in upper half of sequence space |
| win_code | output | 2 | Encoded receive window size |
| win_err | output | 1 | Last receive strobe carried an illegal size |
| ctx_update | output | 1 | One-cycle pulse on an overlap flip |

## Verification
The hardest situation to reach is the bottom landing exactly on the midpoint, one packet either side of it. The stimulus sets the low word to 2^31 + size − 1 to set the bit, then one less to clear it, with two window sizes. Two flipping strobes are also issued on consecutive cycles, so the pulse is seen twice with no gap. After an illegal receive size, a strobe with low word 0 follows while the stored high word is non-zero. This checks that the forcing to 1 depends on the earlier high word and not on the new one.

// File: rtl/esn_trk_pkg.sv
package esn_trk_pkg;

    localparam int unsigned SEQ_W  = 32;
    localparam int unsigned WSZ_W  = 16;
    localparam int unsigned CODE_W = 2;
    localparam int unsigned N_WIN  = 1 << CODE_W;
    localparam int unsigned MIN_WIN = 32;

    typedef struct packed {
        logic [SEQ_W-1:0] lo;
        logic [SEQ_W-1:0] hi;
    } seq_pair_t;

    typedef enum logic [CODE_W-1:0] {
        WIN_32  = 2'd0,
        WIN_64  = 2'd1,
        WIN_128 = 2'd2,
        WIN_256 = 2'd3
    } win_code_e;

    function automatic logic [SEQ_W-1:0] calc_bottom(input logic [SEQ_W-1:0] seq,
                                                     input logic [SEQ_W-1:0] win);
        if (seq >= win)
            return seq - win + SEQ_W'(1);
        return '0;
    endfunction

endpackage

// File: rtl/esn_win_decode.sv
module esn_win_decode
    import esn_trk_pkg::*;
#(
    parameter int unsigned SZ_W = WSZ_W
) (
    input  logic [SZ_W-1:0]   size,
    output logic [CODE_W-1:0] code,
    output logic              legal
);
    logic [N_WIN-1:0] hit;

    for (genvar k = 0; k < N_WIN; k++) begin : g_cmp
        assign hit[k] = (size == SZ_W'(MIN_WIN << k));
    end

    always_comb begin
        code  = '0;
        legal = |hit;
        for (int k = 0; k < N_WIN; k++)
            if (hit[k]) code = CODE_W'(k);
    end

    // R7
    always_comb begin
        if (legal)
            legal_pow2_chk: assert ($countones(size) == 1);
    end
endmodule

// File: rtl/esn_bottom_calc.sv
module esn_bottom_calc
    import esn_trk_pkg::*;
#(
    parameter int unsigned SW   = SEQ_W,
    parameter int unsigned SZ_W = WSZ_W
) (
    input  logic [SW-1:0]   seq,
    input  logic [SZ_W-1:0] size,
    output logic [SW-1:0]   bottom,
    output logic            upper
);
    logic [SW-1:0] size_ext;

    assign size_ext = SW'(size);
    assign bottom   = calc_bottom(seq, size_ext);
    assign upper    = bottom[SW-1];

    // R1
    always_comb begin
        if (size_ext != '0)
            bottom_le_seq_chk: assert (bottom <= seq);
    end
endmodule

// File: rtl/esn_state_reg.sv
module esn_state_reg
    import esn_trk_pkg::*;
#(
    parameter int unsigned SW = SEQ_W,
    parameter int unsigned CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_valid,
    input  logic          dir_rx,
    input  logic          reject,
    input  logic [CW-1:0] code_in,
    input  logic [SW-1:0] lo_in,
    input  logic [SW-1:0] hi_in,
    input  logic [SW-1:0] bottom_in,
    input  logic          upper_in,
    output logic [SW-1:0] lo_q,
    output logic [SW-1:0] hi_q,
    output logic [SW-1:0] bottom_q,
    output logic          overlap_q,
    output logic [CW-1:0] code_q,
    output logic          err_q,
    output logic          pulse_q
);
    logic [SW-1:0] lo_next;

    assign lo_next = (hi_q == '0 && lo_in == '0) ? SW'(1) : lo_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q      <= '0;
            hi_q      <= '0;
            bottom_q  <= '0;
            overlap_q <= 1'b0;
            code_q    <= '0;
            err_q     <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (upd_valid) begin
                err_q <= reject;
                if (!reject) begin
                    lo_q     <= lo_next;
                    hi_q     <= hi_in;
                    bottom_q <= bottom_in;
                    if (dir_rx)
                        code_q <= code_in;
                    if (overlap_q != upper_in) begin
                        overlap_q <= upper_in;
                        pulse_q   <= 1'b1;
                    end
                end
            end
        end
    end

    // R6
    pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> $past(upd_valid));

    // R2
    overlap_flip_flagged_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && overlap_q != $past(overlap_q)) |-> pulse_q);

    // R4
    first_seq_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && !$past(reject) && $past(hi_q) == '0) |-> (lo_q != '0));

    // R8
    reject_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && $past(reject)) |-> ($stable(lo_q) && $stable(overlap_q) && err_q));

    // R7
    tx_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && !$past(dir_rx)) |-> $stable(code_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid)) |-> ($stable(lo_q) && $stable(hi_q) && !pulse_q));
endmodule

// File: rtl/esn_track_top.sv
module esn_track_top
    import esn_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              dir_rx,
    input  logic [SEQ_W-1:0]  rx_seq_lo,
    input  logic [SEQ_W-1:0]  rx_seq_hi,
    input  logic [SEQ_W-1:0]  tx_seq_lo,
    input  logic [SEQ_W-1:0]  tx_seq_hi,
    input  logic [WSZ_W-1:0]  win_size,
    output logic [SEQ_W-1:0]  seq_lo,
    output logic [SEQ_W-1:0]  seq_hi,
    output logic [SEQ_W-1:0]  win_bottom,
    output logic              overlap,
    output logic [CODE_W-1:0] win_code,
    output logic              win_err,
    output logic              ctx_update
);
    seq_pair_t         sel;
    logic [CODE_W-1:0] code;
    logic              legal;
    logic              reject;
    logic [SEQ_W-1:0]  bottom;
    logic              upper;

    assign sel    = dir_rx ? '{lo: rx_seq_lo, hi: rx_seq_hi}
                           : '{lo: tx_seq_lo, hi: tx_seq_hi};
    assign reject = dir_rx && !legal;

    esn_win_decode #(.SZ_W(WSZ_W)) u_dec (
        .size  (win_size),
        .code  (code),
        .legal (legal)
    );

    esn_bottom_calc #(.SW(SEQ_W), .SZ_W(WSZ_W)) u_bot (
        .seq    (sel.lo),
        .size   (win_size),
        .bottom (bottom),
        .upper  (upper)
    );

    esn_state_reg #(.SW(SEQ_W), .CW(CODE_W)) u_st (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (upd_valid),
        .dir_rx    (dir_rx),
        .reject    (reject),
        .code_in   (code),
        .lo_in     (sel.lo),
        .hi_in     (sel.hi),
        .bottom_in (bottom),
        .upper_in  (upper),
        .lo_q      (seq_lo),
        .hi_q      (seq_hi),
        .bottom_q  (win_bottom),
        .overlap_q (overlap),
        .code_q    (win_code),
        .err_q     (win_err),
        .pulse_q   (ctx_update)
    );
endmodule

// File: tb/sim_esn_track_top.sv
module sim_esn_track_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_valid = 1'b0;
    logic        dir_rx = 1'b0;
    logic [31:0] rx_seq_lo = '0, rx_seq_hi = '0, tx_seq_lo = '0, tx_seq_hi = '0;
    logic [15:0] win_size = '0;
    logic [31:0] seq_lo, seq_hi, win_bottom;
    logic        overlap, win_err, ctx_update;
    logic [1:0]  win_code;

    always #2 clk = ~clk;

    esn_track_top u0 (.*);

    typedef struct {
        logic [31:0] lo, hi, bot;
        logic        ov, upd, err;
        logic [1:0]  code;
    } exp_t;

    exp_t q[$];
    exp_t m;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input exp_t e);
        chk("R5", "seq_lo (R4 forcing)", seq_lo, e.lo);
        chk("R5", "seq_hi", seq_hi, e.hi);
        chk("R1", "win_bottom", win_bottom, e.bot);
        chk("R3", "overlap (R2 clear)", {31'd0, overlap}, {31'd0, e.ov});
        chk("R6", "ctx_update", {31'd0, ctx_update}, {31'd0, e.upd});
        chk("R7", "win_code", {30'd0, win_code}, {30'd0, e.code});
        chk("R8", "win_err", {31'd0, win_err}, {31'd0, e.err});
    endtask

    // Driver: applies one strobe and pushes the expected outcome.
    task automatic strobe(input bit rx, input logic [31:0] rlo, rhi, tlo, thi,
                          input logic [15:0] w, input bit gap);
        logic [31:0] lo, hi, bot;
        bit legal, rej;
        logic [1:0] c;
        @(negedge clk);
        dir_rx = rx; rx_seq_lo = rlo; rx_seq_hi = rhi;
        tx_seq_lo = tlo; tx_seq_hi = thi; win_size = w; upd_valid = 1'b1;
        lo = rx ? rlo : tlo;
        hi = rx ? rhi : thi;
        legal = 1'b1;
        case (w)
            16'd32:  c = 2'd0;
            16'd64:  c = 2'd1;
            16'd128: c = 2'd2;
            16'd256: c = 2'd3;
            default: begin c = 2'd0; legal = 1'b0; end
        endcase
        rej = rx && !legal;
        m.err = rej;
        m.upd = 1'b0;
        if (!rej) begin
            bot = (lo >= {16'd0, w}) ? lo - {16'd0, w} + 32'd1 : 32'd0;
            m.lo = (m.hi == 0 && lo == 0) ? 32'd1 : lo;
            m.hi = hi;
            m.bot = bot;
            if (rx) m.code = c;
            if (m.ov && bot < 32'h8000_0000) begin m.ov = 1'b0; m.upd = 1'b1; end
            else if (!m.ov && bot >= 32'h8000_0000) begin m.ov = 1'b1; m.upd = 1'b1; end
        end
        q.push_back(m);
        if (gap) begin
            @(negedge clk);
            upd_valid = 1'b0;
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R10", "idle ctx_update", {31'd0, ctx_update}, 32'd0);
        chk("R10", "idle seq_lo", seq_lo, m.lo);
    endtask

    // Monitor: pops one expected item per strobe seen at a clock edge.
    initial begin
        forever begin
            @(posedge clk);
            if (upd_valid && !rst) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 scoreboard empty: actual 1 expected 0");
                end else begin
                    compare_all(q.pop_front());
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        m = '{lo: 0, hi: 0, bot: 0, ov: 0, upd: 0, err: 0, code: 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        @(negedge clk);
        chk("R9", "reset seq_lo", seq_lo, 0);
        chk("R9", "reset seq_hi", seq_hi, 0);
        chk("R9", "reset bottom", win_bottom, 0);
        chk("R9", "reset overlap", {31'd0, overlap}, 0);
        chk("R9", "reset win_code", {30'd0, win_code}, 0);
        chk("R9", "reset err/update", {30'd0, win_err, ctx_update}, 0);

        // R4: zero low word with zero stored high word is forced to 1
        strobe(1, 32'h0, 32'h0, 32'h55, 32'h66, 16'd64, 1);
        idle_check();
        // R3: bottom exactly at midpoint sets overlap
        strobe(1, 32'h8000_001F, 32'h0, 32'h1, 32'h2, 16'd32, 1);
        idle_check();
        // R2: bottom one below midpoint clears overlap
        strobe(1, 32'h8000_001E, 32'h0, 32'h1, 32'h2, 16'd32, 1);
        // R5/R7: transmit pair stored, code kept, odd size no error
        strobe(0, 32'h11, 32'h22, 32'h9000_0000, 32'h5, 16'd100, 1);
        idle_check();
        // R8: illegal receive size refused
        strobe(1, 32'h7, 32'h9, 32'h3, 32'h4, 16'd100, 1);
        idle_check();
        // R4: stored high non-zero, zero low word stays zero; R2 clears
        strobe(1, 32'h0, 32'h0, 32'hAA, 32'hBB, 16'd256, 1);
        // R1: low word below window gives bottom 0
        strobe(1, 32'd10, 32'h3, 32'h0, 32'h0, 16'd256, 1);
        // R1: midpoint with size 128 boundary
        strobe(1, 32'h8000_007F, 32'h3, 32'h0, 32'h0, 16'd128, 1);
        strobe(1, 32'h8000_007E, 32'h3, 32'h0, 32'h0, 16'd128, 1);
        // R6: back-to-back flipping strobes, two consecutive pulses
        strobe(1, 32'hF000_0000, 32'h4, 32'h0, 32'h0, 16'd64, 0);
        strobe(0, 32'h0, 32'h0, 32'h100, 32'h4, 16'd64, 1);
        idle_check();
        // R7: illegal size on transmit no error, size 256 on receive code 3
        strobe(0, 32'h0, 32'h0, 32'hC000_0000, 32'h4, 16'd0, 1);
        strobe(1, 32'hFFFF_FFFF, 32'h8, 32'h0, 32'h0, 16'd256, 1);
        idle_check();

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R6 leftover items: actual %0d expected 0", q.size());
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule